// File: doc/BRIEF.md
# Reset and Clock Start-up Sequencer

This block sorts incoming reset requests into cold and warm kinds, picks the oscillator mode that applies once the reset is over, and keeps the processor core in reset until that oscillator is usable. A power-on or brown-out request is cold. A cold request loads the mode from the non-volatile configuration field. Any other request is warm, and that includes a software reset. A warm request keeps the mode that is active at that moment.

Once the requests have gone away and the supplies are reported stable, the sequencer walks through the start-up stages that the chosen mode needs, always in the same order. The first stage waits for a done pulse from an external start-up delay timer. The second stage counts oscillator periods on the raw oscillator clock, and its result crosses into the sequencer clock through two flops. The third stage counts PLL lock ticks. If a new request arrives during any stage, the sequence is abandoned and starts again from the beginning.

Top module: `clk_start_seq`

## Requirements
- R1: A power-on or brown-out request loads `sel_mode` with the normalized `cfg_mode` on the next edge. When a cold request and a warm request arrive in the same cycle, the cold source is used.
- R2: A warm or software request loads `sel_mode` with the normalized `cur_mode`. While no request is present, `sel_mode` does not change.
- R3: Mode codes are 0 internal RC, 1 RC/16, 2 RC/N, 3 RC+PLL, 4 XT, 5 HS, 6 external clock, 7 XT+PLL, 8 HS+PLL, 9 external+PLL, 10 secondary oscillator and 11 low-power RC. Codes 12 to 15 act as code 0 and are shown as 0 on `sel_mode`.
- R4: `core_rst` is high unless `clk_ready` is high and `supply_ok` is high. No stage starts until `supply_ok` is high with no request present.
- R5: The stages used by each mode are as follows. Codes 0, 1, 2 and 11 use the delay only. Code 3 uses the delay and then the PLL. Codes 4, 5 and 10 use the delay and then the oscillator timer. Codes 7 and 8 use all three stages. Code 6 uses no stage. Code 9 uses the PLL only.
- R6: Stages run in the order delay, then oscillator timer, then PLL. The delay stage ends on the first `osd_done` pulse that arrives while that stage is active.
- R7: The oscillator timer counts `OST_CYCLES` rising edges of `osc_clk` after its start has been synchronized. It hands over to the sequencer through a two-flop synchronizer.
- R8: The PLL stage ends on the `LOCK_TICKS`-th `pll_tick` seen while the stage is active.
- R9: Any request during a stage, or while running, aborts the sequence. `clk_ready` is low after the next edge, and the sequence restarts from the first stage that applies.
- R10: `clk_ready` rises, and `core_rst` falls with it when supplies are stable, on the edge at which the last required stage completes. Both then hold until a new request arrives.
- R11: After `arst_n` is released, the core stays in reset and `sel_mode` reads 0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| osc_clk | input | 1 | Raw oscillator clock for the period counter |
| arst_n | input | 1 | Asynchronous register clear, active low |
| por_req | input | 1 | Power-on reset request |
| bor_req | input | 1 | Brown-out reset request |
| warm_req | input | 1 | Other warm reset request |
| sw_req | input | 1 | Software reset request |
| supply_ok | input | 1 | Supplies stable |
| cfg_mode | input | 4 | Configured default clock mode |
| cur_mode | input | 4 | Currently active clock mode |
| osd_done | input | 1 | Start-up delay timer done pulse |
| pll_tick | input | 1 | PLL lock reference tick |
| sel_mode | output | 4 | Selected clock mode |
| core_rst | output | 1 | Core reset hold |
| clk_ready | output | 1 | Chosen clock is ready |

## Verification
Most internal faults show up at the ports as a change in when `clk_ready` rises. This covers a wrong stage list, a skipped or repeated stage, an off-by-one in a counter, or an extra flop in the handshake. The reference model predicts the exact cycle of that rise, so such a fault appears as a mismatch on the first cycle where the two disagree. This is at most one stage length after the fault. A wrong mode source or a wrong decode of the unused codes shows on `sel_mode` one edge after the request. An abort that is not honoured shows as `clk_ready` still high on the next cycle.

// File: rtl/clk_start_seq.sv
module clk_start_seq #(
  parameter int OST_CYCLES = 1024,
  parameter int LOCK_TICKS = 1500
) (
  input  logic       clk,
  input  logic       osc_clk,
  input  logic       arst_n,
  input  logic       por_req,
  input  logic       bor_req,
  input  logic       warm_req,
  input  logic       sw_req,
  input  logic       supply_ok,
  input  logic [3:0] cfg_mode,
  input  logic [3:0] cur_mode,
  input  logic       osd_done,
  input  logic       pll_tick,
  output logic [3:0] sel_mode,
  output logic       core_rst,
  output logic       clk_ready
);
  localparam int OW = $clog2(OST_CYCLES + 1);
  localparam int LW = $clog2(LOCK_TICKS + 1);

  typedef enum logic [2:0] {ST_WAIT, ST_SUP, ST_OSD, ST_OST, ST_PLL, ST_RUN} st_t;
  st_t state, nxt, first_st, after_osd, after_ost;

  function automatic logic [3:0] norm(input logic [3:0] m);
    return (m > 4'd11) ? 4'd0 : m;
  endfunction

  logic          any_req, cold_req;
  logic          need_osd, need_ost, need_pll;
  logic [LW-1:0] pll_cnt;
  logic          pll_last;
  logic          ost_run;
  logic [1:0]    run_s;
  logic [OW-1:0] ost_cnt;
  logic          ost_done;
  logic [1:0]    done_s;
  logic          ost_sync;

  assign any_req  = por_req | bor_req | warm_req | sw_req;
  assign cold_req = por_req | bor_req;
  assign ost_sync = done_s[1];

  assign need_osd = !(sel_mode == 4'd6 || sel_mode == 4'd9);
  assign need_ost = sel_mode inside {4'd4, 4'd5, 4'd7, 4'd8, 4'd10};
  assign need_pll = sel_mode inside {4'd3, 4'd7, 4'd8, 4'd9};

  assign after_ost = need_pll ? ST_PLL : ST_RUN;
  assign after_osd = need_ost ? ST_OST : after_ost;
  assign first_st  = need_osd ? ST_OSD : after_osd;
  assign pll_last  = pll_tick && (pll_cnt == LW'(LOCK_TICKS - 1));

  always_comb begin
    nxt = state;
    if (any_req) nxt = ST_SUP;
    else begin
      case (state)
        ST_SUP: if (supply_ok && !(need_ost && ost_sync)) nxt = first_st;
        ST_OSD: if (osd_done) nxt = after_osd;
        ST_OST: if (ost_sync) nxt = after_ost;
        ST_PLL: if (pll_last) nxt = ST_RUN;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= ST_WAIT;
      sel_mode <= 4'd0;
      pll_cnt  <= '0;
      ost_run  <= 1'b0;
      done_s   <= 2'b00;
    end else begin
      state   <= nxt;
      ost_run <= (nxt == ST_OST);
      done_s  <= {done_s[0], ost_done};
      if (any_req) sel_mode <= cold_req ? norm(cfg_mode) : norm(cur_mode);
      if (state != ST_PLL || any_req) pll_cnt <= '0;
      else if (pll_tick) pll_cnt <= pll_cnt + 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge arst_n) begin
    if (!arst_n) begin
      run_s    <= 2'b00;
      ost_cnt  <= '0;
      ost_done <= 1'b0;
    end else begin
      run_s <= {run_s[0], ost_run};
      if (!run_s[1]) begin
        ost_cnt  <= '0;
        ost_done <= 1'b0;
      end else if (!ost_done) begin
        if (ost_cnt == OW'(OST_CYCLES - 1)) ost_done <= 1'b1;
        else ost_cnt <= ost_cnt + 1'b1;
      end
    end
  end

  assign clk_ready = (state == ST_RUN);
  assign core_rst  = !(clk_ready && supply_ok);

  p_abort_r9: assert property (@(posedge clk) disable iff (!arst_n)
    any_req |=> !clk_ready);
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !any_req |=> $stable(sel_mode));
  p_ready_keep_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (clk_ready && !any_req) |=> clk_ready);
  p_osd_exit_r6: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(state) == ST_OSD && state != ST_OSD && !$past(any_req)) |-> $past(osd_done));
  p_ost_exit_r7: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(state) == ST_OST && state != ST_OST && !$past(any_req)) |-> $past(ost_sync));
  p_pll_exit_r8: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(state) == ST_PLL && state == ST_RUN) |-> $past(pll_tick));
endmodule

// File: tb/sim_clk_start_seq.sv
module sim_clk_start_seq;
  localparam int OSTN = 1024;
  localparam int LOCKN = 1500;

  logic clk = 0, osc_clk = 0, arst_n = 1;
  logic por_req = 0, bor_req = 0, warm_req = 0, sw_req = 0, supply_ok = 1;
  logic [3:0] cfg_mode = 0, cur_mode = 0;
  logic osd_done = 0, pll_tick = 0;
  logic [3:0] sel_mode;
  logic core_rst, clk_ready;

  clk_start_seq #(.OST_CYCLES(OSTN), .LOCK_TICKS(LOCKN)) u0 (
    .clk(clk), .osc_clk(osc_clk), .arst_n(arst_n), .por_req(por_req), .bor_req(bor_req),
    .warm_req(warm_req), .sw_req(sw_req), .supply_ok(supply_ok), .cfg_mode(cfg_mode),
    .cur_mode(cur_mode), .osd_done(osd_done), .pll_tick(pll_tick), .sel_mode(sel_mode),
    .core_rst(core_rst), .clk_ready(clk_ready));

  always #10 clk = ~clk;
  initial begin #5; forever #10 osc_clk = ~osc_clk; end

  int checks = 0, fails = 0, cyc = 0, bg = 0;
  string tag = "R11";

  // behavioural model: 0 idle, 1 supply wait, 2 delay, 3 osc timer, 4 pll, 5 running
  int m_mode = 0, m_stage = 0, age = 0, pc = 0;
  bit m_ready = 0;
  int q[$];

  function automatic int nm(input int x); return (x > 11) ? 0 : x; endfunction

  task automatic step_next();
    age = 0; pc = 0;
    if (q.size() == 0) begin m_stage = 5; m_ready = 1; end
    else m_stage = q.pop_front();
  endtask

  always @(posedge clk) begin
    if (!arst_n) begin
      m_mode = 0; m_stage = 0; m_ready = 0; q.delete();
    end else if (por_req || bor_req || warm_req || sw_req) begin
      m_mode = (por_req || bor_req) ? nm(cfg_mode) : nm(cur_mode);
      m_ready = 0; m_stage = 1; q.delete();
      case (m_mode)
        3: q = '{2, 4};
        4, 5, 10: q = '{2, 3};
        7, 8: q = '{2, 3, 4};
        6: q.delete();
        9: q = '{4};
        default: q = '{2};
      endcase
    end else begin
      case (m_stage)
        1: if (supply_ok) step_next();
        2: if (osd_done) step_next();
        3: if (age == OSTN + 3) step_next(); else age++;
        4: if (pll_tick) begin if (pc == LOCKN - 1) step_next(); else pc++; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    bg++;
    osd_done = (bg % 7 == 0);
    pll_tick = (bg % 2 == 1);
  end

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    chk(clk_ready == m_ready, tag, "clk_ready", clk_ready, m_ready);
    chk(sel_mode == m_mode[3:0], tag, "sel_mode", sel_mode, m_mode);
    chk(core_rst == !(m_ready && supply_ok), tag, "core_rst", core_rst, !(m_ready && supply_ok));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic req(input bit p, input bit b, input bit w, input bit s);
    @(negedge clk);
    por_req = p; bor_req = b; warm_req = w; sw_req = s;
    @(negedge clk);
    por_req = 0; bor_req = 0; warm_req = 0; sw_req = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!m_ready && n < 20000) begin @(negedge clk); n++; end
    #3;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int n;
    #1 arst_n = 0;
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (20) @(negedge clk);
    #3;
    tag = "R11";
    chk(core_rst == 1, "R11", "core_rst idle", core_rst, 1);
    chk(clk_ready == 0, "R11", "clk_ready idle", clk_ready, 0);

    tag = "R1"; cfg_mode = 0; cur_mode = 5;
    req(1, 0, 0, 0); wait_ready(n);
    chk(sel_mode == 0, "R1", "por mode", sel_mode, 0);
    chk(n < 12, "R5", "delay-only length", n, 12);

    tag = "R3"; cfg_mode = 14;
    req(1, 0, 0, 0); wait_ready(n);
    chk(sel_mode == 0, "R3", "unused code", sel_mode, 0);

    tag = "R7"; cfg_mode = 4;
    req(0, 1, 0, 0); wait_ready(n);
    chk(n >= OSTN + 4, "R7", "osc timer length", n, OSTN + 4);
    chk(sel_mode == 4, "R1", "bor mode", sel_mode, 4);

    tag = "R8"; cfg_mode = 0; cur_mode = 8;
    req(0, 0, 1, 0); wait_ready(n);
    chk(sel_mode == 8, "R2", "warm mode", sel_mode, 8);
    chk(n >= OSTN + 2 * LOCKN, "R8", "pll length", n, OSTN + 2 * LOCKN);

    tag = "R5"; cur_mode = 6;
    req(0, 0, 0, 1); wait_ready(n);
    chk(n <= 2, "R5", "external clock no wait", n, 2);
    chk(sel_mode == 6, "R2", "sw mode", sel_mode, 6);

    tag = "R5"; cfg_mode = 9;
    req(1, 0, 0, 0); wait_ready(n);
    chk(n >= 2 * LOCKN - 2 && n < 2 * LOCKN + 4, "R5", "pll-only length", n, 2 * LOCKN);

    tag = "R4"; supply_ok = 0; cfg_mode = 11;
    req(1, 0, 0, 0);
    repeat (50) @(negedge clk);
    #3;
    chk(clk_ready == 0, "R4", "held without supply", clk_ready, 0);
    @(negedge clk); supply_ok = 1;
    tag = "R10";
    wait_ready(n);
    chk(core_rst == 0, "R10", "released", core_rst, 0);
    @(negedge clk); supply_ok = 0;
    #3;
    chk(core_rst == 1, "R4", "supply drop", core_rst, 1);
    chk(clk_ready == 1, "R10", "ready kept", clk_ready, 1);
    @(negedge clk); supply_ok = 1;
    repeat (5) @(negedge clk);

    tag = "R9"; cfg_mode = 7; cur_mode = 3;
    req(1, 0, 0, 0);
    repeat (300) @(negedge clk);
    req(0, 0, 1, 0);
    #3;
    chk(clk_ready == 0, "R9", "aborted", clk_ready, 0);
    chk(sel_mode == 3, "R9", "restart mode", sel_mode, 3);
    wait_ready(n);

    tag = "R1"; cfg_mode = 5; cur_mode = 8;
    req(1, 0, 1, 0); wait_ready(n);
    chk(sel_mode == 5, "R1", "cold wins", sel_mode, 5);

    tag = "R6"; cfg_mode = 10;
    req(1, 0, 0, 0); wait_ready(n);
    chk(sel_mode == 10, "R6", "secondary osc", sel_mode, 10);
    tag = "R2";
    repeat (20) @(negedge clk);
    #3;
    chk(sel_mode == 10 && clk_ready == 1, "R2", "hold without request", sel_mode, 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule